// File: doc/BRIEF.md
# Active/Alternate Stack Pointer Pair

This block keeps the two stack pointers of a processor core as a pair of registers, called active and alternate, rather than as fixed supervisor and user registers. The core reads and writes only the active pointer. When the processor changes privilege mode, the block swaps the contents of the two registers in one clock edge. The active register then always holds the pointer of the current mode.

The block keeps its own copy of the supervisor bit. While that bit is 1, the active register holds the supervisor pointer and the alternate register holds the user pointer. While the bit is 0 the roles are reversed. A debug port reads and writes the two physical registers by their active/alternate names. The debug host turns these into supervisor and user names itself, using the supervisor bit that the block exposes.

All writes that arrive in a cycle go into the registers first. A pending role swap is applied after them, on the same edge.

Top module: `stackPtrPair`

## Requirements
- R1: Reset (rstN low) clears both the active and the alternate register to zero and sets supBit to 1.
- R2: When coreWe is high, the active register takes coreWdata at the next rising edge. coreRdata always shows the active register, and the alternate register is not changed by a core write.
- R3: When modeWe is high and modeVal differs from supBit, supBit takes modeVal at the next edge. When modeWe is high and modeVal equals supBit, or when modeWe is low, supBit and both registers are unchanged (absent other writes).
- R4: A change of supBit exchanges the contents of the active and alternate registers on the same edge, so the pointer of the new mode becomes active.
- R5: dbgRdata shows the active register when dbgSel is 0 and the alternate register when dbgSel is 1, combinationally.
- R6: When dbgWe is high, the register chosen by dbgSel (0 active, 1 alternate) takes dbgWdata at the next edge.
- R7: A core write in the same cycle as a mode change is applied before the swap, so the written value ends up in the alternate register.
- R8: If dbgWe is high with dbgSel 0 in the same cycle as coreWe, the active register takes dbgWdata and coreWdata is discarded.
- R9: A debug write to the alternate register in the same cycle as a mode change is applied before the swap, so the written value becomes active.
- R10: With coreWe, dbgWe and modeWe all low, both registers and supBit hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| coreWe | input | 1 | Core write strobe for the active pointer |
| coreWdata | input | DATA_W | Core write value |
| coreRdata | output | DATA_W | Active pointer contents |
| modeWe | input | 1 | Mode update strobe |
| modeVal | input | 1 | New supervisor bit value |
| supBit | output | 1 | Current supervisor bit |
| dbgWe | input | 1 | Debug write strobe |
| dbgSel | input | 1 | Debug register select: 0 active, 1 alternate |
| dbgWdata | input | DATA_W | Debug write value |
| dbgRdata | output | DATA_W | Contents of the selected register |

## Verification
The assertions assume only that the strobes and dbgSel are at known levels on every clock edge after reset; any combination of the three write strobes is legal. The bench drives every strobe and select at random, so core, debug and mode writes, including those that collide, occur in every combination. Directed steps aim the collision cases at fixed register contents. This lets the ordering rules (writes first, then the swap) be read from the register values.

// File: rtl/stackPtrPkg.sv
`timescale 1ns/1ps
package stackPtrPkg;

  typedef enum logic {
    DBG_ACTIVE    = 1'b0,
    DBG_ALTERNATE = 1'b1
  } dbgSel_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic actCoreLd;  // load active from core data
    logic actDbgLd;   // load active from debug data
    logic altDbgLd;   // load alternate from debug data
    logic swapRoles;  // exchange active/alternate after loads
  } spStrobes_t;

endpackage

// File: rtl/stackPtrCtrl.sv
`timescale 1ns/1ps
module stackPtrCtrl
  import stackPtrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreWe,
  input  logic       dbgWe,
  input  logic       dbgSel,
  input  logic       modeWe,
  input  logic       modeVal,
  output spStrobes_t strb,
  output logic       supBit
);

  logic supBitQ;
  logic modeToggle;
  logic dbgHitsActive;
  logic dbgHitsAlt;

  assign modeToggle    = modeWe && (modeVal != supBitQ);
  assign dbgHitsActive = dbgWe && (dbgSel == DBG_ACTIVE);
  assign dbgHitsAlt    = dbgWe && (dbgSel == DBG_ALTERNATE);

  always_comb begin
    strb           = '0;
    strb.actDbgLd  = dbgHitsActive;
    strb.actCoreLd = coreWe && !dbgHitsActive;  // debug wins on active
    strb.altDbgLd  = dbgHitsAlt;
    strb.swapRoles = modeToggle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) supBitQ <= 1'b1;
    else if (modeToggle) supBitQ <= modeVal;
  end

  assign supBit = supBitQ;

  AST_SUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && (modeVal != supBitQ)) |=> (supBitQ == $past(modeVal))); // R3

  AST_SUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWe || (modeVal == supBitQ)) |=> $stable(supBitQ)); // R3

  AST_CORE_YIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (coreWe && dbgWe && (dbgSel == DBG_ACTIVE)) |-> !strb.actCoreLd); // R8

  AST_ONE_ACT_SRC: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.actCoreLd && strb.actDbgLd)); // R8

endmodule

// File: rtl/stackPtrData.sv
`timescale 1ns/1ps
module stackPtrData
  import stackPtrPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobes_t        strb,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] dbgWdata,
  input  logic              dbgSel,
  output logic [DATA_W-1:0] activeOut,
  output logic [DATA_W-1:0] dbgOut
);

  localparam logic [DATA_W-1:0] RESET_VAL = '0;

  logic [DATA_W-1:0] activeQ, altQ;
  logic [DATA_W-1:0] actPre, altPre;
  logic [DATA_W-1:0] activeD, altD;

  // Stage 1: apply writes
  always_comb begin
    actPre = activeQ;
    if (strb.actCoreLd) actPre = coreWdata;
    if (strb.actDbgLd)  actPre = dbgWdata;
    altPre = strb.altDbgLd ? dbgWdata : altQ;
  end

  // Stage 2: role swap after writes
  always_comb begin
    if (strb.swapRoles) begin
      activeD = altPre;
      altD    = actPre;
    end else begin
      activeD = actPre;
      altD    = altPre;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= RESET_VAL;
      altQ    <= RESET_VAL;
    end else begin
      activeQ <= activeD;
      altQ    <= altD;
    end
  end

  assign activeOut = activeQ;
  assign dbgOut    = (dbgSel == DBG_ALTERNATE) ? altQ : activeQ;

  AST_SWAP_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swapRoles && !strb.altDbgLd) |=> (activeQ == $past(altQ))); // R4

  AST_SWAP_TO_ALT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swapRoles && !strb.actCoreLd && !strb.actDbgLd) |=> (altQ == $past(activeQ))); // R4

  AST_CORE_BEFORE_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swapRoles && strb.actCoreLd) |=> (altQ == $past(coreWdata))); // R7

  AST_DBG_ALT_BEFORE_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swapRoles && strb.altDbgLd) |=> (activeQ == $past(dbgWdata))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(activeQ) && $stable(altQ))); // R10

endmodule

// File: rtl/stackPtrPair.sv
`timescale 1ns/1ps
module stackPtrPair
  import stackPtrPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreWe,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              modeWe,
  input  logic              modeVal,
  output logic              supBit,
  input  logic              dbgWe,
  input  logic              dbgSel,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic [DATA_W-1:0] dbgRdata
);

  spStrobes_t strb;

  stackPtrCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .coreWe  (coreWe),
    .dbgWe   (dbgWe),
    .dbgSel  (dbgSel),
    .modeWe  (modeWe),
    .modeVal (modeVal),
    .strb    (strb),
    .supBit  (supBit)
  );

  stackPtrData #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .coreWdata (coreWdata),
    .dbgWdata  (dbgWdata),
    .dbgSel    (dbgSel),
    .activeOut (coreRdata),
    .dbgOut    (dbgRdata)
  );

endmodule

// File: tb/stackPtrPair_tb.sv
`timescale 1ns/1ps
module stackPtrPair_tb;

  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              coreWe = 1'b0;
  logic [DATA_W-1:0] coreWdata = '0;
  logic [DATA_W-1:0] coreRdata;
  logic              modeWe = 1'b0;
  logic              modeVal = 1'b0;
  logic              supBit;
  logic              dbgWe = 1'b0;
  logic              dbgSel = 1'b0;
  logic [DATA_W-1:0] dbgWdata = '0;
  logic [DATA_W-1:0] dbgRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] actM = '0, altM = '0;
  logic              supM = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  stackPtrPair #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .coreWe(coreWe), .coreWdata(coreWdata), .coreRdata(coreRdata),
    .modeWe(modeWe), .modeVal(modeVal), .supBit(supBit),
    .dbgWe(dbgWe), .dbgSel(dbgSel), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model of one edge: writes first, debug wins on active, then swap
  function automatic void modelStep(input logic cw, input logic [DATA_W-1:0] cd,
                                    input logic dw, input logic ds,
                                    input logic [DATA_W-1:0] dd,
                                    input logic mw, input logic mv);
    logic [DATA_W-1:0] a, b;
    a = actM; b = altM;
    if (cw) a = cd;
    if (dw && !ds) a = dd;
    if (dw && ds)  b = dd;
    if (mw && (mv != supM)) begin
      actM = b; altM = a; supM = mv;
    end else begin
      actM = a; altM = b;
    end
  endfunction

  task automatic cycle(input logic cw, input logic [DATA_W-1:0] cd,
                       input logic dw, input logic ds, input logic [DATA_W-1:0] dd,
                       input logic mw, input logic mv);
    @(negedge clk);
    coreWe = cw; coreWdata = cd; dbgWe = dw; dbgSel = ds; dbgWdata = dd;
    modeWe = mw; modeVal = mv;
    modelStep(cw, cd, dw, ds, dd, mw, mv);
    @(posedge clk);
    #2;
    coreWe = 1'b0; dbgWe = 1'b0; modeWe = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    dbgSel = 1'b0; #1;
    check({tag, " R2 coreRdata"}, coreRdata, actM);
    check({tag, " R5 dbg active"}, dbgRdata, actM);
    dbgSel = 1'b1; #1;
    check({tag, " R5 dbg alternate"}, dbgRdata, altM);
    check({tag, " R3 supBit"}, {{(DATA_W-1){1'b0}}, supBit}, {{(DATA_W-1){1'b0}}, supM});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] hold0, hold1;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #3;
    checkAll("R1 reset");
    @(negedge clk) rstN = 1'b1;

    // R2: core write to active only
    cycle(1'b1, 32'hAAAA_0001, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    checkAll("R2 core write");
    // R6: debug write alternate
    cycle(1'b0, '0, 1'b1, 1'b1, 32'hBBBB_0002, 1'b0, 1'b0);
    checkAll("R6 debug alt write");
    // R4: toggle to user, roles swap
    cycle(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    checkAll("R4 swap");
    check("R4 active now former alternate", coreRdata, 32'hBBBB_0002);
    // R3: same-value mode write has no effect
    cycle(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    checkAll("R3 same mode");
    check("R3 no swap", coreRdata, 32'hBBBB_0002);
    // R7: core write together with toggle
    cycle(1'b1, 32'hCCCC_0003, 1'b0, 1'b0, '0, 1'b1, 1'b1);
    checkAll("R7 core+toggle");
    dbgSel = 1'b1; #1;
    check("R7 written value in alternate", dbgRdata, 32'hCCCC_0003);
    // R8: debug and core both on active
    cycle(1'b1, 32'hDDDD_0004, 1'b1, 1'b0, 32'hEEEE_0005, 1'b0, 1'b0);
    checkAll("R8 collision");
    check("R8 debug wins", coreRdata, 32'hEEEE_0005);
    // R9: debug alternate write together with toggle
    cycle(1'b0, '0, 1'b1, 1'b1, 32'h1234_5678, 1'b1, 1'b0);
    checkAll("R9 dbg alt+toggle");
    check("R9 written value active", coreRdata, 32'h1234_5678);
    // R6: debug write active
    cycle(1'b0, '0, 1'b1, 1'b0, 32'h0F0F_0F0F, 1'b0, 1'b0);
    checkAll("R6 debug active write");
    // R10: idle holds
    hold0 = actM; hold1 = altM;
    cycle(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1);
    checkAll("R10 idle");
    check("R10 active held", coreRdata, hold0);
    dbgSel = 1'b1; #1;
    check("R10 alternate held", dbgRdata, hold1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      cycle(1'($urandom), $urandom, 1'($urandom), 1'($urandom), $urandom,
            1'($urandom), 1'($urandom));
      checkAll("R10 random");
    end

    // R1: reset again mid-run
    @(negedge clk) rstN = 1'b0;
    actM = '0; altM = '0; supM = 1'b1;
    #3;
    checkAll("R1 second reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule